// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral watches over system software with a 32-bit down-counter. Software sets a reload value and turns on counting. If the count runs out, the block raises an interrupt and starts a second countdown from the same reload value. Software then has one more full period to clear the interrupt. If that period also runs out while the interrupt is still pending and reset generation is turned on, the block drives a system reset. The reset stays asserted until software clears the interrupt or stops the watchdog.

The register bus is a plain single-cycle port: a word address, a write strobe, write data, and read data that follows the address combinationally. Stray writes to the timing registers are blocked by a key-protected lock. Only after the exact key has been written to the lock register do writes to the reload, control and clear registers take effect. Any other value written to the lock register closes it again.

The behaviour is held in a five-state machine:
- **IDLE**: stopped, nothing pending.
- **FIRST**: counting, no interrupt.
- **SECOND**: counting, interrupt pending.
- **BARK**: reset asserted, count frozen at zero.
- **PARKED**: stopped with an interrupt still pending.

Its transitions are:
- **start**: IDLE to FIRST, when counting is turned on.
- **expire**: FIRST to SECOND.
- **bite**: SECOND to BARK, on a second expiry with reset enabled.
- **service**: SECOND, BARK or PARKED to FIRST (or to IDLE when counting is off), on a clear write.
- **stop**: FIRST to IDLE, or SECOND and BARK to PARKED, when counting is turned off.
- **resume**: PARKED to SECOND.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset: control reads 0, reload (0x000) and count (0x004) read 0xFFFFFFFF, lock (0xC00) reads 1, and both irq_o and sys_rst_o are low.
- R2: Writing 0x1ACCE551 to 0xC00 opens the lock, and the lock register then reads 0. Writing any other value closes it, and it reads 1.
- R3: While the lock is closed, writes to reload (0x000), control (0x008) and clear (0x00C) change nothing. Reads always work.
- R4: With control bit 0 set, the count drops by one per clock. An unlocked write to reload sets both the reload value and the count immediately.
- R5: When the count is at zero with no interrupt pending, the next cycle sets raw status bit 0 (0x010) and reloads the count, which gives a period of reload+1 cycles.
- R6: With control bit 1 set, a second expiry while the interrupt is pending raises sys_rst_o exactly reload+1 cycles after the interrupt rose. The count then stays at zero and sys_rst_o stays high.
- R7: With control bit 1 clear, a second expiry reloads the count, keeps the interrupt pending and never raises sys_rst_o.
- R8: Masked status bit 0 (0x014) and irq_o equal raw status bit 0 ANDed with control bit 0.
- R9: An unlocked write of any data to clear (0x00C) removes the pending interrupt, drops sys_rst_o and reloads the count.
- R10: Writing control bit 0 as 0 stops the count, which then holds its value, and drops sys_rst_o. A pending interrupt stays visible in raw status until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Masked interrupt |
| sys_rst_o | output | 1 | System reset request |

## Verification
The countdown is exercised in three ways:
- **Reload writes while running**: checks that a reload takes effect on the next cycle and is not deferred to the next expiry.
- **Two expiries with reset generation off**: separates the interrupt-only path from the reset path.
- **The interrupt-to-reset interval with reset generation on**: counted in cycles, it shows that the second period is a full reload+1 and not shortened or lengthened by one.

Writes while the lock is closed are each followed by a readback of the register they target. Stopping with an interrupt pending shows raw and masked status diverging.

// File: rtl/wdog_pkg.sv
`timescale 1ns/100ps
package wdog_pkg;

    // Register word offsets (byte addresses)
    localparam int OFS_LOAD  = 'h000;
    localparam int OFS_COUNT = 'h004;
    localparam int OFS_CTRL  = 'h008;
    localparam int OFS_CLEAR = 'h00C;
    localparam int OFS_RAW   = 'h010;
    localparam int OFS_MASK  = 'h014;
    localparam int OFS_LOCK  = 'hC00;

    // Control field layout
    localparam int CTRL_W   = 2;
    localparam int CTRL_RUN = 0;
    localparam int CTRL_RST = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_BARK,
        ST_PARKED
    } wd_state_e;

endpackage

// File: rtl/wdog_lock.sv
`timescale 1ns/100ps
module wdog_lock #(
    parameter int          ADDR_W = 12,
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              unlocked
);
    import wdog_pkg::*;

    logic hit;
    assign hit = bus_we && (bus_addr == ADDR_W'(OFS_LOCK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (hit) begin
            unlocked <= (bus_wdata == DATA_W'(KEY));
        end
    end

endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/100ps
module wdog_regs #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        unlocked,
    output logic [DATA_W-1:0]           load_q,
    output logic [wdog_pkg::CTRL_W-1:0] ctrl_q,
    output logic                        load_wr,
    output logic                        clr_wr,
    output logic [DATA_W-1:0]           reload_val
);
    import wdog_pkg::*;

    logic cfg_ok;
    logic ctrl_wr;

    assign cfg_ok  = bus_we && unlocked;
    assign load_wr = cfg_ok && (bus_addr == ADDR_W'(OFS_LOAD));
    assign ctrl_wr = cfg_ok && (bus_addr == ADDR_W'(OFS_CTRL));
    assign clr_wr  = cfg_ok && (bus_addr == ADDR_W'(OFS_CLEAR));

    // A reload write is seen by the counter in the same cycle as the register
    assign reload_val = load_wr ? bus_wdata : load_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '1;
            ctrl_q <= '0;
        end else begin
            if (load_wr) load_q <= bus_wdata;
            if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/100ps
module wdog_core #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                rst_en,
    input  logic                load_wr,
    input  logic                clr_wr,
    input  logic [DATA_W-1:0]   reload_val,
    input  logic [DATA_W-1:0]   load_q,
    output logic [DATA_W-1:0]   cnt_q,
    output wdog_pkg::wd_state_e state_q,
    output logic                irq_raw,
    output logic                bark
);
    import wdog_pkg::*;

    wd_state_e nxt;
    logic      at_zero;
    logic      counting;
    logic      expire;

    assign at_zero  = (cnt_q == '0);
    assign counting = en && ((state_q == ST_FIRST) || (state_q == ST_SECOND));
    assign expire   = counting && at_zero && !load_wr && !clr_wr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) nxt = ST_FIRST;                     // start
            end
            ST_FIRST: begin
                if (!en)         nxt = ST_IDLE;             // stop
                else if (expire) nxt = ST_SECOND;           // expire
            end
            ST_SECOND: begin
                if (clr_wr)                nxt = en ? ST_FIRST : ST_IDLE;  // service
                else if (!en)              nxt = ST_PARKED;                // stop
                else if (expire && rst_en) nxt = ST_BARK;                  // bite
            end
            ST_BARK: begin
                if (clr_wr)   nxt = en ? ST_FIRST : ST_IDLE; // service
                else if (!en) nxt = ST_PARKED;               // stop
            end
            ST_PARKED: begin
                if (clr_wr)  nxt = en ? ST_FIRST : ST_IDLE;  // service
                else if (en) nxt = ST_SECOND;                // resume
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_raw = (state_q == ST_SECOND) || (state_q == ST_BARK) || (state_q == ST_PARKED);
        bark    = (state_q == ST_BARK);
    end

    // Down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (clr_wr || (load_wr && state_q != ST_BARK)) begin
            cnt_q <= reload_val;
        end else if (counting) begin
            if (at_zero) cnt_q <= (state_q == ST_SECOND && rst_en) ? '0 : load_q;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_two_stage.sv
`timescale 1ns/100ps
module wdog_two_stage #(
    parameter int          ADDR_W = 12,
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    import wdog_pkg::*;

    logic              unlocked;
    logic [DATA_W-1:0] load_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              load_wr;
    logic              clr_wr;
    logic [DATA_W-1:0] reload_val;
    logic [DATA_W-1:0] cnt_q;
    wd_state_e         state_q;
    logic              irq_raw;
    logic              bark;

    wdog_lock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_lock (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .unlocked(unlocked)
    );

    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .unlocked(unlocked), .load_q(load_q),
        .ctrl_q(ctrl_q), .load_wr(load_wr), .clr_wr(clr_wr),
        .reload_val(reload_val)
    );

    wdog_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[CTRL_RUN]), .rst_en(ctrl_q[CTRL_RST]),
        .load_wr(load_wr), .clr_wr(clr_wr), .reload_val(reload_val),
        .load_q(load_q), .cnt_q(cnt_q), .state_q(state_q),
        .irq_raw(irq_raw), .bark(bark)
    );

    assign irq_o     = irq_raw && ctrl_q[CTRL_RUN];
    assign sys_rst_o = bark;

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_LOAD):  bus_rdata = load_q;
            ADDR_W'(OFS_COUNT): bus_rdata = cnt_q;
            ADDR_W'(OFS_CTRL):  bus_rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFS_RAW):   bus_rdata = DATA_W'(irq_raw);
            ADDR_W'(OFS_MASK):  bus_rdata = DATA_W'(irq_o);
            ADDR_W'(OFS_LOCK):  bus_rdata = DATA_W'(!unlocked);
            default:            bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_two_stage_chk.sv
`timescale 1ns/100ps
module wdog_two_stage_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic                unlocked,
    input logic [DATA_W-1:0]   load_q,
    input logic [1:0]          ctrl_q,
    input logic [DATA_W-1:0]   cnt_q,
    input logic                load_wr,
    input logic                clr_wr,
    input wdog_pkg::wd_state_e state_q,
    input logic                irq_raw,
    input logic                irq_o,
    input logic                sys_rst_o
);
    import wdog_pkg::*;

    assert_locked_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_we && bus_addr == ADDR_W'(OFS_LOAD)) |=> $stable(load_q));

    assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_we && bus_addr == ADDR_W'(OFS_CTRL)) |=> $stable(ctrl_q));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && (state_q == ST_FIRST || state_q == ST_SECOND) &&
         cnt_q != '0 && !load_wr && !clr_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_bark_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (cnt_q == '0));

    assert_bark_after_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(irq_raw));

    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |-> !irq_o);

    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (!irq_raw && !sys_rst_o));

    assert_stopped_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[0] && !load_wr && !clr_wr) |=> $stable(cnt_q));

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .unlocked(unlocked), .load_q(load_q), .ctrl_q(ctrl_q), .cnt_q(cnt_q),
    .load_wr(load_wr), .clr_wr(clr_wr), .state_q(state_q),
    .irq_raw(irq_raw), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/sim_wdog_two_stage.sv
`timescale 1ns/100ps
module sim_wdog_two_stage;

    localparam logic [31:0] KEY = 32'h1ACCE551;
    localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                            A_CLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                            A_LOCK = 12'hC00;
    localparam int K_RD = 0, K_IRQ = 1, K_RST = 2, K_MEAS = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        sys_rst_o;

    item_t       sb[$];
    logic        chk_req = 1'b0;
    logic [31:0] meas = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_two_stage u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .sys_rst_o(sys_rst_o)
    );

    // Monitor: pops one expected item per request and compares
    always @(negedge clk) begin
        if (chk_req) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL scoreboard empty: actual none expected item");
            end else begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_IRQ:   act = 32'(irq_o);
                    K_RST:   act = 32'(sys_rst_o);
                    default: act = meas;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #0.5;
        bus_we = 1'b0;
    endtask

    task automatic push_req(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        chk_req = 1'b1;
        @(negedge clk); #0.5;
        chk_req = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        push_req(K_RD, exp, tag);
    endtask

    task automatic pin(input int kind, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        push_req(kind, exp, tag);
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 500 && !irq_o; i++) @(negedge clk);
    endtask

    localparam logic [31:0] L = 32'd10;

    initial begin : main
        logic [31:0] held;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, 32'h0, "R1 control");
        rd(A_LOAD, 32'hFFFFFFFF, "R1 reload");
        rd(A_CNT, 32'hFFFFFFFF, "R1 count");
        rd(A_LOCK, 32'h1, "R1 lock");
        pin(K_IRQ, 0, "R1 irq_o");
        pin(K_RST, 0, "R1 sys_rst_o");

        // R3 writes ignored while locked
        wr(A_LOAD, 32'd5);
        rd(A_LOAD, 32'hFFFFFFFF, "R3 locked reload");
        rd(A_CNT, 32'hFFFFFFFF, "R3 locked count");
        wr(A_CTRL, 32'd3);
        rd(A_CTRL, 32'h0, "R3 locked control");

        // R2 lock key
        wr(A_LOCK, KEY);
        rd(A_LOCK, 32'h0, "R2 opened");
        wr(A_LOCK, 32'h1);
        rd(A_LOCK, 32'h1, "R2 closed");
        wr(A_LOAD, 32'd7);
        rd(A_LOAD, 32'hFFFFFFFF, "R3 relocked reload");
        wr(A_LOCK, KEY);

        // R4 counting and immediate reload
        wr(A_LOAD, 32'd20);
        wr(A_CTRL, 32'd1);
        rd(A_CNT, 32'd20, "R4 first count");
        rd(A_CNT, 32'd19, "R4 decrement");
        wr(A_LOAD, 32'd30);
        rd(A_CNT, 32'd29, "R4 reload while running");
        rd(A_LOAD, 32'd30, "R4 reload register");

        // R5 first expiry
        wr(A_LOAD, L);
        wait_irq();
        rd(A_CNT, L - 1, "R5 reloaded after expiry");
        rd(A_RAW, 32'h1, "R5 raw status");
        rd(A_MASK, 32'h1, "R8 masked status running");
        pin(K_IRQ, 1, "R8 irq_o");

        // R7 second expiry without reset enable
        repeat (30) @(posedge clk);
        pin(K_RST, 0, "R7 no reset");
        rd(A_RAW, 32'h1, "R7 still pending");

        // R9 clear
        wr(A_CLR, 32'h0);
        rd(A_CNT, L - 1, "R9 clear reloads");
        rd(A_RAW, 32'h0, "R9 raw cleared");

        // R6 reset after second expiry
        wr(A_CTRL, 32'd3);
        wait_irq();
        n = 0;
        while (!sys_rst_o && n < 500) begin @(negedge clk); n++; end
        meas = 32'(n);
        pin(K_MEAS, L + 1, "R6 irq to reset cycles");
        repeat (5) @(posedge clk);
        pin(K_RST, 1, "R6 reset held");
        rd(A_CNT, 32'h0, "R6 count at zero");
        wr(A_CLR, 32'h0);
        pin(K_RST, 0, "R9 reset dropped by clear");
        pin(K_IRQ, 0, "R9 irq dropped by clear");

        // R10 stop with pending interrupt
        wait_irq();
        wr(A_CTRL, 32'd0);
        rd(A_RAW, 32'h1, "R10 raw kept after stop");
        rd(A_MASK, 32'h0, "R8 masked off after stop");
        pin(K_IRQ, 0, "R8 irq_o off after stop");
        peek(A_CNT, held);
        repeat (5) @(posedge clk);
        rd(A_CNT, held, "R10 count held");
        wr(A_LOCK, 32'h0);
        wr(A_CLR, 32'h0);
        rd(A_RAW, 32'h1, "R3 locked clear ignored");
        wr(A_LOCK, KEY);
        wr(A_CLR, 32'h0);
        rd(A_RAW, 32'h0, "R9 clear from stopped");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule